// File: doc/BRIEF.md
# Four-Operand Pipelined Carry-Save Adder

This block sums four N-bit operands in a two-stage pipeline. The operands are first widened by two guard bits, so that the total of four values always fits. Two rows of three-input carry-save cells then collapse them into a pair of redundant vectors. Each cell forms a parity bit and a majority bit, and no carry travels along the row. A single ripple-carry stage at the end turns the redundant pair into an ordinary binary result.

Registers sit after the first carry-save row and after the second. The block therefore takes a new operand set on every clock edge, and each result leaves exactly two edges after its operands were sampled. An input strobe travels down a matching valid chain alongside the data. The `SIGNED` parameter is fixed at elaboration. It selects whether operands are zero-extended or sign-extended, and which rule the overflow flag follows. Callers get the exact widened total, its low N bits, the first bit above those N bits, and a flag that says the N-bit result does not hold the exact total.

Top module: `csa4_pipe_adder`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a rising edge), `out_valid` is 0 and `sum_wide` is 0.
- R2: Operands and `in_valid` sampled at rising edge k produce their result, and `out_valid` equal to that `in_valid`, on the outputs after rising edge k+2 (latency of two edges).
- R3: Operand sets presented on consecutive edges each produce their own correct result on consecutive edges, with no gaps.
- R4: With `SIGNED`=0, `sum_wide` (N+2 bits) equals the exact unsigned total of the four operands.
- R5: With `SIGNED`=1, `sum_wide` equals the exact two's-complement total of the four operands, written as an N+2-bit two's-complement value.
- R6: `sum` equals bits N-1..0 of `sum_wide`.
- R7: `carry_out` equals bit N of `sum_wide`.
- R8: With `SIGNED`=0, `overflow` is 1 exactly when the total exceeds 2^N - 1, that is, when any of bits N+1..N of `sum_wide` is set.
- R9: With `SIGNED`=1, `overflow` is 1 exactly when the total lies outside -2^(N-1)..2^(N-1)-1, that is, when bits N+1..N-1 of `sum_wide` are not all equal.
- R10: Data moves through the pipeline on every edge whatever `in_valid` is. A cycle with `in_valid` low gives `out_valid` low two edges later, while the data outputs still carry that cycle's total.
- R11: A reset held while operands are in flight and `in_valid` is high removes them all. After one reset edge, `out_valid` is 0 and `sum_wide` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks the operand set on this edge as meaningful |
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| op_c | input | N | Third operand |
| op_d | input | N | Fourth operand |
| out_valid | output | 1 | Delayed copy of `in_valid`, aligned with the result |
| sum_wide | output | N+2 | Exact total of the four operands |
| sum | output | N | Low N bits of the total |
| carry_out | output | 1 | Bit N of the total |
| overflow | output | 1 | The N-bit result does not hold the exact total |

## Verification
One unsigned and one signed instance share the same stimulus, so every pattern tests both extension rules. All-zero, all-ones, most-negative and most-positive operand sets push the guard bits to their limits and switch the two overflow rules in opposite ways; all-ones, for instance, overflows unsigned but not signed. A long back-to-back random stream tests that adjacent results do not mix. A pattern that alternates the strobe tests that valid and data stay aligned when data keeps moving without valid. A reset applied while valid operands are in flight tests that nothing left over reaches the outputs.

// File: rtl/csa4_pkg.sv
// Shared constants and bit-level functions for the four-operand adder.
// Assumes: callers size their vectors to N + CSA_GUARD_BITS.
package csa4_pkg;

    // Extra high-order bits that hold the growth of four operands.
    localparam int CSA_GUARD_BITS = 2;

    // Register stages between operand capture and the result.
    localparam int CSA_PIPE_DEPTH = 2;

    // Number of operands taken per cycle.
    localparam int CSA_NUM_OPS = 4;

    // Odd parity of three bits: the sum output of a carry-save cell.
    function automatic logic parity3(input logic x, input logic y, input logic z);
        return x ^ y ^ z;
    endfunction

    // Two-of-three majority: the carry output of a carry-save cell.
    function automatic logic major3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/csa4_extend.sv
// Widens one N-bit operand to N+2 bits, either by zero fill or by copying
// the sign bit, as chosen by SIGNED at elaboration.
// Assumes: N >= 2.
module csa4_extend #(
    parameter int N      = 8,
    parameter bit SIGNED = 1'b0
) (
    input  logic [N-1:0]                         op_in,
    output logic [N+csa4_pkg::CSA_GUARD_BITS-1:0] op_out
);
    import csa4_pkg::*;

    localparam int G = CSA_GUARD_BITS;

    generate
        if (SIGNED) begin : g_sign_fill
            // Copy the operand's sign into the guard bits.
            assign op_out = {{G{op_in[N-1]}}, op_in};
        end else begin : g_zero_fill
            // Unsigned operands get zero guard bits.
            assign op_out = {{G{1'b0}}, op_in};
        end
    endgenerate

endmodule

// File: rtl/csa4_row.sv
// One row of carry-save cells. It turns three W-bit vectors into a parity
// vector and a saved-carry vector. The carry from bit i feeds bit i+1 of the
// saved-carry vector, bit 0 of that vector is zero, and the carry out of the
// top bit is dropped, so the row preserves the total modulo 2^W.
// Assumes: pure combinational logic; its depth is one cell at any width.
module csa4_row #(
    parameter int W = 10
) (
    input  logic [W-1:0] in_x,
    input  logic [W-1:0] in_y,
    input  logic [W-1:0] in_z,
    output logic [W-1:0] par_vec,
    output logic [W-1:0] cry_vec
);
    import csa4_pkg::*;

    // Nothing is carried into the least significant position.
    assign cry_vec[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_cell
            // Parity bit of this cell stays at its own weight.
            assign par_vec[i] = parity3(in_x[i], in_y[i], in_z[i]);
            if (i < W - 1) begin : g_keep_carry
                // Majority bit moves one place up on the saved-carry vector.
                assign cry_vec[i+1] = major3(in_x[i], in_y[i], in_z[i]);
            end
        end
    endgenerate

endmodule

// File: rtl/csa4_ripple.sv
// Ripple-carry adder that resolves a redundant pair into one binary word,
// modulo 2^W. The carry chain passes through every bit in turn.
// Assumes: carry-in is zero; the caller needs no carry out of the top bit.
module csa4_ripple #(
    parameter int W = 10
) (
    input  logic [W-1:0] add_x,
    input  logic [W-1:0] add_y,
    output logic [W-1:0] add_sum
);
    import csa4_pkg::*;

    logic [W-1:0] chain;

    // Carry entering bit 0.
    assign chain[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_fa
            // Sum bit from both inputs and the incoming carry.
            assign add_sum[i] = parity3(add_x[i], add_y[i], chain[i]);
            if (i < W - 1) begin : g_next
                // Carry handed on to the next bit.
                assign chain[i+1] = major3(add_x[i], add_y[i], chain[i]);
            end
        end
    endgenerate

endmodule

// File: rtl/csa4_pipe_adder.sv
// Top of the four-operand adder. Operands are widened by two guard bits,
// reduced by carry-save row 1 and registered, reduced by row 2 together with
// the fourth operand and registered again, then resolved by a ripple adder.
// Every register loads on every edge; a valid bit travels beside the data.
// Assumes: synchronous active-low reset; operands are held around the
// sampling edge.
module csa4_pipe_adder #(
    parameter int N      = 8,
    parameter bit SIGNED = 1'b0
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   in_valid,
    input  logic [N-1:0]                           op_a,
    input  logic [N-1:0]                           op_b,
    input  logic [N-1:0]                           op_c,
    input  logic [N-1:0]                           op_d,
    output logic                                   out_valid,
    output logic [N+csa4_pkg::CSA_GUARD_BITS-1:0]  sum_wide,
    output logic [N-1:0]                           sum,
    output logic                                   carry_out,
    output logic                                   overflow
);
    import csa4_pkg::*;

    localparam int W   = N + CSA_GUARD_BITS;
    localparam int NOP = CSA_NUM_OPS;

    // ---------------- operand widening ----------------
    logic [N-1:0] op_arr  [NOP];
    logic [W-1:0] ext_arr [NOP];

    assign op_arr[0] = op_a;
    assign op_arr[1] = op_b;
    assign op_arr[2] = op_c;
    assign op_arr[3] = op_d;

    genvar k;
    generate
        for (k = 0; k < NOP; k++) begin : g_ext
            csa4_extend #(.N(N), .SIGNED(SIGNED)) u_ext (
                .op_in  (op_arr[k]),
                .op_out (ext_arr[k])
            );
        end
    endgenerate

    // ---------------- stage 1: first carry-save row ----------------
    logic [W-1:0] row1_par, row1_cry;

    csa4_row #(.W(W)) u_row1 (
        .in_x    (ext_arr[0]),
        .in_y    (ext_arr[1]),
        .in_z    (ext_arr[2]),
        .par_vec (row1_par),
        .cry_vec (row1_cry)
    );

    logic [W-1:0] p1_par_q, p1_cry_q, p1_opd_q;
    logic         p1_vld_q;

    // Capture the first reduction and the unused fourth operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p1_par_q <= '0;
            p1_cry_q <= '0;
            p1_opd_q <= '0;
            p1_vld_q <= 1'b0;
        end else begin
            p1_par_q <= row1_par;
            p1_cry_q <= row1_cry;
            p1_opd_q <= ext_arr[3];
            p1_vld_q <= in_valid;
        end
    end

    // ---------------- stage 2: second carry-save row ----------------
    logic [W-1:0] row2_par, row2_cry;

    csa4_row #(.W(W)) u_row2 (
        .in_x    (p1_par_q),
        .in_y    (p1_cry_q),
        .in_z    (p1_opd_q),
        .par_vec (row2_par),
        .cry_vec (row2_cry)
    );

    logic [W-1:0] p2_par_q, p2_cry_q;
    logic         p2_vld_q;

    // Capture the redundant pair in front of the final adder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p2_par_q <= '0;
            p2_cry_q <= '0;
            p2_vld_q <= 1'b0;
        end else begin
            p2_par_q <= row2_par;
            p2_cry_q <= row2_cry;
            p2_vld_q <= p1_vld_q;
        end
    end

    // ---------------- final carry-propagate stage ----------------
    csa4_ripple #(.W(W)) u_cpa (
        .add_x   (p2_par_q),
        .add_y   (p2_cry_q),
        .add_sum (sum_wide)
    );

    assign out_valid = p2_vld_q;
    assign sum       = sum_wide[N-1:0];
    assign carry_out = sum_wide[N];

    generate
        if (SIGNED) begin : g_ovf_signed
            // Signed range is lost unless bits W-1..N-1 all match.
            assign overflow = ~((&sum_wide[W-1:N-1]) | ~(|sum_wide[W-1:N-1]));
        end else begin : g_ovf_unsigned
            // Unsigned range is lost when any guard bit is set.
            assign overflow = |sum_wide[W-1:N];
        end
    endgenerate

    // ---------------- assertions ----------------
    logic [1:0]   run_age;
    logic [W-1:0] in_total, p1_total;

    // Count edges since reset ended, saturating, so $past is only used
    // over cycles that followed a reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_age <= 2'd0;
        else if (run_age != 2'd3)
            run_age <= run_age + 2'd1;
    end

    // Reference totals of each stage's inputs, used only by the checks.
    always_comb begin
        in_total = ext_arr[0] + ext_arr[1] + ext_arr[2] + ext_arr[3];
        p1_total = p1_par_q + p1_cry_q + p1_opd_q;
    end

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R11
    reset_flush_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && (sum_wide == '0)));

    // R4
    stage1_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_age >= 2'd1) |-> (p1_total == $past(in_total)));

    // R4
    stage2_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_age >= 2'd1) |-> (W'(p2_par_q + p2_cry_q) == $past(p1_total)));

    // R4
    final_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum_wide == W'(p2_par_q + p2_cry_q));

endmodule

// File: tb/csa4_pipe_adder_bench.sv
`timescale 1ns/1ps
module csa4_pipe_adder_bench;

    localparam int N = 8;
    localparam int W = N + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [N-1:0] op_a = '0, op_b = '0, op_c = '0, op_d = '0;

    logic         u_vld, s_vld, u_cy, s_cy, u_ov, s_ov;
    logic [W-1:0] u_wide, s_wide;
    logic [N-1:0] u_sum, s_sum;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    csa4_pipe_adder #(.N(N), .SIGNED(1'b0)) u_csa4_pipe_adder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
        .out_valid(u_vld), .sum_wide(u_wide), .sum(u_sum),
        .carry_out(u_cy), .overflow(u_ov)
    );

    csa4_pipe_adder #(.N(N), .SIGNED(1'b1)) u_csa4_pipe_adder_s (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
        .out_valid(s_vld), .sum_wide(s_wide), .sum(s_sum),
        .carry_out(s_cy), .overflow(s_ov)
    );

    typedef struct packed {
        logic       v;
        logic [7:0] a, b, c, d;
    } vec_t;

    vec_t h0 = '0, h1 = '0;

    task automatic cmp(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare both instances against the vector driven two steps earlier.
    task automatic check_pair(string vtag, vec_t e);
        int eu, es, wu, ws;
        eu = int'(e.a) + int'(e.b) + int'(e.c) + int'(e.d);
        es = int'($signed(e.a)) + int'($signed(e.b)) + int'($signed(e.c)) + int'($signed(e.d));
        wu = eu & 1023;
        ws = es & 1023;
        cmp(vtag, "valid unsigned", int'(u_vld), int'(e.v));
        cmp(vtag, "valid signed", int'(s_vld), int'(e.v));
        cmp("R4", "wide unsigned", int'(u_wide), wu);
        cmp("R5", "wide signed", int'(s_wide), ws);
        cmp("R6", "sum unsigned", int'(u_sum), eu & 255);
        cmp("R6", "sum signed", int'(s_sum), es & 255);
        cmp("R7", "carry unsigned", int'(u_cy), (wu >> 8) & 1);
        cmp("R7", "carry signed", int'(s_cy), (ws >> 8) & 1);
        cmp("R8", "overflow unsigned", int'(u_ov), (eu > 255) ? 1 : 0);
        cmp("R9", "overflow signed", int'(s_ov), ((es > 127) || (es < -128)) ? 1 : 0);
    endtask

    // One cycle: check the result due now, then drive the next operands.
    task automatic step(string vtag, logic v, logic [7:0] a, logic [7:0] b,
                        logic [7:0] c, logic [7:0] d);
        @(negedge clk);
        check_pair(vtag, h1);
        h1 = h0;
        h0 = '{v: v, a: a, b: b, c: c, d: d};
        in_valid = v;
        op_a = a; op_b = b; op_c = c; op_d = d;
    endtask

    task automatic drain(string vtag);
        step(vtag, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0);
        step(vtag, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0);
    endtask

    // Reset with whatever inputs are applied; check the cleared outputs.
    task automatic do_reset(string req);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        cmp(req, "valid unsigned in reset", int'(u_vld), 0);
        cmp(req, "valid signed in reset", int'(s_vld), 0);
        cmp(req, "wide unsigned in reset", int'(u_wide), 0);
        cmp(req, "wide signed in reset", int'(s_wide), 0);
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
        op_a = '0; op_b = '0; op_c = '0; op_d = '0;
        h0 = '0;
        h1 = '0;
    endtask

    // R2: one isolated vector; valid must appear only in its own slot.
    task automatic t_latency();
        step("R2", 1'b0, 8'd0, 8'd0, 8'd0, 8'd0);
        step("R2", 1'b1, 8'd17, 8'd40, 8'd3, 8'd99);
        drain("R2");
        step("R2", 1'b0, 8'd0, 8'd0, 8'd0, 8'd0);
    endtask

    // R4 R5 R8 R9: extreme operand sets.
    task automatic t_extremes();
        step("R2", 1'b1, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        step("R2", 1'b1, 8'h80, 8'h80, 8'h80, 8'h80);
        step("R2", 1'b1, 8'h7F, 8'h7F, 8'h7F, 8'h7F);
        step("R2", 1'b1, 8'h00, 8'h00, 8'h00, 8'h00);
        step("R2", 1'b1, 8'h7F, 8'h01, 8'h00, 8'h00);
        step("R2", 1'b1, 8'h80, 8'hFF, 8'h00, 8'h00);
        step("R2", 1'b1, 8'hFF, 8'h01, 8'h00, 8'h00);
        drain("R2");
    endtask

    // R3: back-to-back random operands.
    task automatic t_stream();
        for (int i = 0; i < 60; i++)
            step("R3", 1'b1, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
        drain("R3");
    endtask

    // R10: valid toggles while data keeps flowing.
    task automatic t_bubbles();
        for (int i = 0; i < 20; i++)
            step("R10", (i % 2) == 0, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
        drain("R10");
    endtask

    // R11: reset during a valid stream flushes it.
    task automatic t_flush();
        for (int i = 0; i < 3; i++)
            step("R11", 1'b1, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
        do_reset("R11");
        drain("R11");
    endtask

    initial begin
        do_reset("R1");
        drain("R1");
        t_latency();
        t_extremes();
        t_stream();
        t_bubbles();
        t_flush();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule